// File: doc/BRIEF.md
# Module Power-Gating Sleep Controller

This controller puts a two-core compute module into a deep sleep state and brings it back out. In that state the module's local ground rail is cut off from true ground by a ring of gating switches. Sleep starts only when every core of the module reports idle in the same cycle. The controller then asks a cache-flush engine to write back the caches, asks a save engine to copy the register state to a save area, clamps the module outputs with isolation, and finally opens both ground switches.

A wake request starts the exit sequence. The weak switch closes first and stays alone for a programmable dwell, which limits inrush current. The strong switch then closes, and a programmable settle dwell follows. Isolation is released, state is restored, and the cores resume in the run state. If a wake request arrives, or a core stops being idle, during the flush or the save, the entry is abandoned and the module goes back to run without being gated.

States: `S_RUN`, `S_FLUSH`, `S_SAVE`, `S_ISOLATE`, `S_GATED`, `S_WAKE_WEAK`, `S_WAKE_STRONG`, `S_RESTORE`. Transitions: run→flush (all idle, no wake); flush→save (flush acknowledge); flush→run and save→run (abort); save→isolate (save acknowledge); isolate→gated (always, after one cycle); gated→wake-weak (wake request); wake-weak→wake-strong (inrush dwell done); wake-strong→restore (settle dwell done); restore→run (restore acknowledge).

Top module: `pg_sleep_ctrl`

## Requirements
- R1: From run, the phase becomes flushing one cycle after a clock edge at which every bit of `core_idle` is 1 and `wake_req` is 0. No other input pattern leaves run.
- R2: While flushing, `flush_req` is 1 until `flush_ack` is seen. While saving, `save_req` is 1 until `save_ack` is seen. Each acknowledge moves the controller one phase forward on the next cycle. At most one of the three request outputs is high at any time.
- R3: After `save_ack`, the controller spends exactly one cycle with isolation on and both switches still on (phase reported as gated). Both switches then turn off.
- R4: If `wake_req` is 1 or any core is not idle at an edge during flushing or saving, the controller returns to run on the next cycle, with neither switch ever turned off. This abort takes priority over an acknowledge sampled at the same edge.
- R5: Gated holds with both switches off until `wake_req` is seen. Then only the weak switch is on for `inrush_cycles`+1 cycles, and the strong switch is never on while the weak switch is off.
- R6: After the inrush dwell, both switches are on and isolation stays on for `settle_cycles`+1 cycles. A value of 0 in either dwell gives a one-cycle dwell.
- R7: Isolation is on in every cycle in which a switch is off. It turns off only once the strong switch is on and the settle dwell has ended.
- R8: In restoring, `restore_req` is 1, both switches are on and isolation is off. The controller returns to run on the cycle after `restore_ack`.
- R9: `phase` encodes run=0, flushing=1, saving=2, gated=3 (including the isolate cycle), waking=4 (both wake dwells), restoring=5. It never shows 6 or 7.
- R10: After reset the phase is run, both switches are on, isolation is off and no request is high.
- R11: An acknowledge that arrives in a phase that does not wait for it has no effect. For example, `flush_ack` in run with a busy core leaves the phase at run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_idle | input | NUM_CORES | Per-core idle flag |
| wake_req | input | 1 | Interrupt or wake request |
| flush_ack | input | 1 | Cache flush done |
| save_ack | input | 1 | State save done |
| restore_ack | input | 1 | State restore done |
| inrush_cycles | input | CNT_W | Weak-switch-only dwell minus one |
| settle_cycles | input | CNT_W | Settle dwell minus one |
| flush_req | output | 1 | Request cache flush |
| save_req | output | 1 | Request state save |
| restore_req | output | 1 | Request state restore |
| weak_sw_en | output | 1 | Small ground switch enable |
| strong_sw_en | output | 1 | Large ground switch enable |
| iso_en | output | 1 | Output isolation clamp enable |
| phase | output | 3 | Current phase code |

## Verification
Every output depends only on the state register. An input sampled at one rising edge therefore shows its effect on the outputs straight after that edge, and a dwell of N+1 cycles shows as N+1 consecutive falling-edge samples. The bench drives inputs at the falling edge and steps a behavioural model at the rising edge. It compares all outputs at the next falling edge, so every result is checked in the cycle it is due. The directed sequences cover a full sleep and wake, aborts in both entry phases, an abort that coincides with an acknowledge, zero-length dwells and a stray acknowledge.

// File: rtl/pg_sleep_pkg.sv
package pg_sleep_pkg;

    typedef enum logic [2:0] {
        S_RUN         = 3'd0,
        S_FLUSH       = 3'd1,
        S_SAVE        = 3'd2,
        S_ISOLATE     = 3'd3,
        S_GATED       = 3'd4,
        S_WAKE_WEAK   = 3'd5,
        S_WAKE_STRONG = 3'd6,
        S_RESTORE     = 3'd7
    } pg_state_t;

    localparam logic [2:0] PH_RUN     = 3'd0;
    localparam logic [2:0] PH_FLUSH   = 3'd1;
    localparam logic [2:0] PH_SAVE    = 3'd2;
    localparam logic [2:0] PH_GATED   = 3'd3;
    localparam logic [2:0] PH_WAKE    = 3'd4;
    localparam logic [2:0] PH_RESTORE = 3'd5;

endpackage

// File: rtl/pg_idle_join.sv
module pg_idle_join #(
    parameter int NUM_CORES = 2
) (
    input  logic [NUM_CORES-1:0] core_idle,
    output logic                 all_idle
);
    // Running AND across the cores, one stage per core.
    logic [NUM_CORES:0] chain;
    assign chain[0] = 1'b1;
    generate
        for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
            assign chain[g+1] = chain[g] & core_idle[g];
        end
    endgenerate
    assign all_idle = chain[NUM_CORES];
endmodule

// File: rtl/pg_dwell_timer.sv
module pg_dwell_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    // The count starts at zero when a state is entered, so done first
    // rises in the (limit+1)-th cycle of that state.
    assign done = (cnt_q == limit);
endmodule

// File: rtl/pg_sleep_ctrl.sv
module pg_sleep_ctrl
    import pg_sleep_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int CNT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] core_idle,
    input  logic                 wake_req,
    input  logic                 flush_ack,
    input  logic                 save_ack,
    input  logic                 restore_ack,
    input  logic [CNT_W-1:0]     inrush_cycles,
    input  logic [CNT_W-1:0]     settle_cycles,
    output logic                 flush_req,
    output logic                 save_req,
    output logic                 restore_req,
    output logic                 weak_sw_en,
    output logic                 strong_sw_en,
    output logic                 iso_en,
    output logic [2:0]           phase
);
    pg_state_t        state_q, state_d;
    logic             all_idle;
    logic             abort_entry;
    logic             dwell_done;
    logic             dwell_clear;
    logic             timed_state;
    logic [CNT_W-1:0] dwell_limit;

    pg_idle_join #(.NUM_CORES(NUM_CORES)) i_idle (
        .core_idle (core_idle),
        .all_idle  (all_idle)
    );

    assign timed_state = (state_q == S_WAKE_WEAK) || (state_q == S_WAKE_STRONG);
    assign dwell_limit = (state_q == S_WAKE_WEAK) ? inrush_cycles : settle_cycles;
    assign dwell_clear = !timed_state || (state_d != state_q);

    pg_dwell_timer #(.CNT_W(CNT_W)) i_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (dwell_clear),
        .limit (dwell_limit),
        .done  (dwell_done)
    );

    assign abort_entry = wake_req || !all_idle;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:         if (all_idle && !wake_req) state_d = S_FLUSH;
            S_FLUSH:       if (abort_entry)           state_d = S_RUN;
                           else if (flush_ack)        state_d = S_SAVE;
            S_SAVE:        if (abort_entry)           state_d = S_RUN;
                           else if (save_ack)         state_d = S_ISOLATE;
            S_ISOLATE:                                state_d = S_GATED;
            S_GATED:       if (wake_req)              state_d = S_WAKE_WEAK;
            S_WAKE_WEAK:   if (dwell_done)            state_d = S_WAKE_STRONG;
            S_WAKE_STRONG: if (dwell_done)            state_d = S_RESTORE;
            S_RESTORE:     if (restore_ack)           state_d = S_RUN;
            default:                                  state_d = S_RUN;
        endcase
    end

    // Moore outputs
    always_comb begin
        flush_req    = 1'b0;
        save_req     = 1'b0;
        restore_req  = 1'b0;
        weak_sw_en   = 1'b1;
        strong_sw_en = 1'b1;
        iso_en       = 1'b0;
        phase        = PH_RUN;
        unique case (state_q)
            S_RUN: ;
            S_FLUSH: begin
                flush_req = 1'b1;
                phase     = PH_FLUSH;
            end
            S_SAVE: begin
                save_req = 1'b1;
                phase    = PH_SAVE;
            end
            S_ISOLATE: begin
                iso_en = 1'b1;
                phase  = PH_GATED;
            end
            S_GATED: begin
                weak_sw_en   = 1'b0;
                strong_sw_en = 1'b0;
                iso_en       = 1'b1;
                phase        = PH_GATED;
            end
            S_WAKE_WEAK: begin
                strong_sw_en = 1'b0;
                iso_en       = 1'b1;
                phase        = PH_WAKE;
            end
            S_WAKE_STRONG: begin
                iso_en = 1'b1;
                phase  = PH_WAKE;
            end
            S_RESTORE: begin
                restore_req = 1'b1;
                phase       = PH_RESTORE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pg_sleep_chk.sv
module pg_sleep_chk #(
    parameter int NUM_CORES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CORES-1:0] core_idle,
    input logic                 wake_req,
    input logic                 flush_req,
    input logic                 save_req,
    input logic                 restore_req,
    input logic                 weak_sw_en,
    input logic                 strong_sw_en,
    input logic                 iso_en,
    input logic [2:0]           phase
);
    AST_ENTRY_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> ($past(&core_idle) && !$past(wake_req))); // R1

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_req, save_req, restore_req})); // R2

    AST_WEAK_UNDER_STRONG: assert property (@(posedge clk) disable iff (!rst_n)
        strong_sw_en |-> weak_sw_en); // R5

    AST_ISO_BEFORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(weak_sw_en) |-> $past(iso_en)); // R3

    AST_ISO_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!weak_sw_en || !strong_sw_en) |-> iso_en); // R7

    AST_ISO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_en) |-> (strong_sw_en && $past(strong_sw_en))); // R7

    AST_RESTORE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |-> (strong_sw_en && !iso_en)); // R8

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= 3'd5); // R9
endmodule

bind pg_sleep_ctrl pg_sleep_chk #(.NUM_CORES(NUM_CORES)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_idle    (core_idle),
    .wake_req     (wake_req),
    .flush_req    (flush_req),
    .save_req     (save_req),
    .restore_req  (restore_req),
    .weak_sw_en   (weak_sw_en),
    .strong_sw_en (strong_sw_en),
    .iso_en       (iso_en),
    .phase        (phase)
);

// File: tb/test_pg_sleep_ctrl.sv
module test_pg_sleep_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 2;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic [NC-1:0] core_idle = '0;
    logic          wake_req = 1'b0;
    logic          flush_ack = 1'b0;
    logic          save_ack = 1'b0;
    logic          restore_ack = 1'b0;
    logic [CW-1:0] inrush_cycles = 8'd3;
    logic [CW-1:0] settle_cycles = 8'd2;
    logic          flush_req, save_req, restore_req;
    logic          weak_sw_en, strong_sw_en, iso_en;
    logic [2:0]    phase;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit compare_on = 1'b0;

    pg_sleep_ctrl #(.NUM_CORES(NC), .CNT_W(CW)) i_pg_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .core_idle(core_idle), .wake_req(wake_req),
        .flush_ack(flush_ack), .save_ack(save_ack), .restore_ack(restore_ack),
        .inrush_cycles(inrush_cycles), .settle_cycles(settle_cycles),
        .flush_req(flush_req), .save_req(save_req), .restore_req(restore_req),
        .weak_sw_en(weak_sw_en), .strong_sw_en(strong_sw_en), .iso_en(iso_en),
        .phase(phase)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model: named phase of the sleep flow plus cycles spent in it.
    // 0 run, 1 flush, 2 save, 3 isolate, 4 gated, 5 weak-on, 6 strong-on, 7 restore
    int m_st = 0;
    int m_age = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_age = 0;
        end else begin
            int nx;
            bool_busy: begin end
            nx = m_st;
            case (m_st)
                0: if (core_idle == '1 && !wake_req) nx = 1;
                1: if (wake_req || core_idle != '1) nx = 0; else if (flush_ack) nx = 2;
                2: if (wake_req || core_idle != '1) nx = 0; else if (save_ack) nx = 3;
                3: nx = 4;
                4: if (wake_req) nx = 5;
                5: if (m_age >= int'(inrush_cycles)) nx = 6;
                6: if (m_age >= int'(settle_cycles)) nx = 7;
                7: if (restore_ack) nx = 0;
                default: nx = 0;
            endcase
            if (nx != m_st) m_age = 0; else m_age = m_age + 1;
            m_st = nx;
        end
    end

    task automatic check1(string tag, string sig, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, sig, act, exp, $time);
        end
    endtask

    // Compare every output against the model at each falling edge.
    always @(negedge clk) begin
        if (compare_on) begin
            int ph;
            case (m_st)
                0: ph = 0; 1: ph = 1; 2: ph = 2; 3: ph = 3; 4: ph = 3;
                5: ph = 4; 6: ph = 4; default: ph = 5;
            endcase
            check1("R9", "phase", int'(phase), ph);
            check1("R2", "flush_req", int'(flush_req), int'(m_st == 1));
            check1("R2", "save_req", int'(save_req), int'(m_st == 2));
            check1("R8", "restore_req", int'(restore_req), int'(m_st == 7));
            check1("R5", "weak_sw_en", int'(weak_sw_en), int'(m_st != 4));
            check1("R6", "strong_sw_en", int'(strong_sw_en), int'(m_st != 4 && m_st != 5));
            check1("R7", "iso_en", int'(iso_en), int'(m_st >= 3 && m_st <= 6));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1 rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        compare_on = 1'b1;
        // R10: reset state
        check1("R10", "phase", int'(phase), 0);
        check1("R10", "switches", int'({weak_sw_en, strong_sw_en, iso_en}), 3'b110);

        // R1: one core busy keeps run
        core_idle = 2'b01; step(4);
        check1("R1", "phase_busy", int'(phase), 0);
        // R11: stray flush_ack in run
        flush_ack = 1'b1; step(1); flush_ack = 1'b0; step(1);
        check1("R11", "phase_stray_ack", int'(phase), 0);

        // Full sleep and wake, inrush 3, settle 2 (R1..R8)
        core_idle = 2'b11; step(1);
        check1("R1", "phase_entry", int'(phase), 1);
        step(2); flush_ack = 1'b1; step(1); flush_ack = 1'b0;
        check1("R2", "phase_save", int'(phase), 2);
        step(1); save_ack = 1'b1; step(1); save_ack = 1'b0;
        check1("R3", "isolate_cycle", int'({weak_sw_en, strong_sw_en, iso_en}), 3'b111);
        step(1);
        check1("R3", "gated_off", int'({weak_sw_en, strong_sw_en}), 0);
        step(5);
        check1("R5", "gated_hold", int'(phase), 3);
        wake_req = 1'b1; step(1); wake_req = 1'b0;
        step(4);
        check1("R6", "strong_after_inrush", int'(strong_sw_en), 1);
        step(3);
        check1("R8", "restore_phase", int'(phase), 5);
        core_idle = 2'b10;
        step(2); restore_ack = 1'b1; step(1); restore_ack = 1'b0;
        check1("R8", "back_to_run", int'(phase), 0);

        // R4: abort during flush via wake
        core_idle = 2'b11; step(2);
        wake_req = 1'b1; step(1);
        check1("R4", "abort_flush", int'(phase), 0);
        core_idle = 2'b00; wake_req = 1'b0; step(1);

        // R4: abort during save via busy core
        core_idle = 2'b11; step(1); flush_ack = 1'b1; step(1); flush_ack = 1'b0;
        step(1); core_idle = 2'b01; step(1);
        check1("R4", "abort_save", int'(phase), 0);

        // R4: abort wins over simultaneous save_ack
        core_idle = 2'b11; step(1); flush_ack = 1'b1; step(1); flush_ack = 1'b0;
        wake_req = 1'b1; save_ack = 1'b1; step(1);
        wake_req = 1'b0; save_ack = 1'b0; core_idle = 2'b00;
        check1("R4", "abort_priority", int'(phase), 0);
        step(1);

        // R6: zero dwells give one cycle each
        inrush_cycles = 8'd0; settle_cycles = 8'd0;
        core_idle = 2'b11; step(1); flush_ack = 1'b1; step(1); flush_ack = 1'b0;
        save_ack = 1'b1; step(1); save_ack = 1'b0; core_idle = 2'b00;
        step(1); wake_req = 1'b1; step(1); wake_req = 1'b0;
        check1("R5", "weak_only", int'({weak_sw_en, strong_sw_en}), 2'b10);
        step(1);
        check1("R6", "strong_one_cycle", int'({strong_sw_en, iso_en}), 2'b11);
        step(1);
        check1("R7", "iso_released", int'(iso_en), 0);
        restore_ack = 1'b1; step(1); restore_ack = 1'b0;
        step(3);

        compare_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule